// File: doc/BRIEF.md
# Multi-Master Bus Request Arbiter

This block sits beside a local bus master and decides, every clock, whether that master must ask for the shared multi-master system bus and whether a bus it already holds may be handed over. The decision comes from the master's three-bit status code, from two static configuration straps that pick one of four operating modes, from a select input that steers an access to the system bus or to a local resident bus, and from three signals describing the other masters: a shared request line, a priority-lost line and two lock lines.

Release is lazy. Once the bus is owned, it is kept through idle and halt-free stretches until another master asks for it, priority is lost, or the master halts. Two lock inputs can hold the bus: one blocks every release, the other blocks only releases caused by the shared request line.

The outputs are a combinational bus-request line and a registered bus-owned flag. Priority resolution among masters, command strobes and timing to the external bus clock are handled elsewhere.

Top module: `mm_bus_arbiter`

## Requirements
- R1: The status code is classed as I/O command for 000, 001 and 010, halt for 011, memory command for 100, 101 and 110, and idle for 111.
- R2: With the bus not owned and no request pending, halt (011) and idle (111) never raise `bus_req`, in any mode.
- R3: Single-bus mode (`cfg_io_split_n`=1, `cfg_local`=0) requests on any I/O or memory status. An owned bus is released on halt, on idle with `share_req`=1, or on `prio_lost`=1.
- R4: Resident-only mode (`cfg_io_split_n`=1, `cfg_local`=1) requests on an I/O or memory status only while `sys_sel`=1. It releases on `share_req`=1 together with idle or `sys_sel`=0, on halt, or on `prio_lost`=1.
- R5: I/O-split mode (`cfg_io_split_n`=0, `cfg_local`=0) requests only on memory commands. It releases on `share_req`=1 together with an I/O or idle status, on halt, or on `prio_lost`=1.
- R6: Combined mode (`cfg_io_split_n`=0, `cfg_local`=1) requests only on memory commands with `sys_sel`=1. It releases on `share_req`=1 together with an I/O status or `sys_sel`=0, on halt, or on `prio_lost`=1.
- R7: `prio_lost`=1 (priority input high, meaning priority lost) releases an owned bus and prevents ownership from being gained.
- R8: While `hold_all`=1, an owned bus is never released.
- R9: While `hold_share`=1, a release caused only by `share_req` is suppressed. Releases caused by halt or by `prio_lost` still take effect.
- R10: `bus_owned` rises on the clock edge where a request (new or pending) is present with `prio_lost`=0. It falls on the edge where a release condition holds and `hold_all`=0.
- R11: `bus_req` stays high from the first requesting status until ownership is gained, and stays high while the bus is owned.
- R12: Synchronous reset clears ownership and any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat | input | 3 | Master status code |
| cfg_io_split_n | input | 1 | Mode strap: low splits I/O away from the system bus |
| cfg_local | input | 1 | Mode strap: high enables the resident-bus select |
| sys_sel | input | 1 | High steers the access to the system bus |
| share_req | input | 1 | Another master wants the bus |
| prio_lost | input | 1 | High when priority has been lost to another master |
| hold_all | input | 1 | Blocks every release |
| hold_share | input | 1 | Blocks releases caused by `share_req` |
| bus_req | output | 1 | Bus request |
| bus_owned | output | 1 | Registered bus ownership flag |

## Verification
`bus_req` is combinational and is due in the same cycle as the status that causes it. The bench drives inputs on the falling edge and checks it one nanosecond later. `bus_owned` is due one rising edge later. Each driven cycle pushes its expected flag into a queue, and a monitor pops that entry five nanoseconds after the next rising edge. Every mode is swept over all eight status codes and every combination of select, shared request, priority loss and the two locks, starting both from an unowned and from an owned bus.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int STAT_W = 3;

    // status classes
    typedef enum logic [1:0] {
        CLS_IO   = 2'd0,
        CLS_HALT = 2'd1,
        CLS_MEM  = 2'd2,
        CLS_IDLE = 2'd3
    } stat_cls_e;

    // {cfg_io_split_n, cfg_local}
    typedef enum logic [1:0] {
        MD_IOSPLIT  = 2'b00,
        MD_COMBINED = 2'b01,
        MD_SINGLE   = 2'b10,
        MD_LOCAL    = 2'b11
    } mode_e;

    typedef struct packed {
        logic want;        // status calls for the bus
        logic share_trig;  // release if another master asks
        logic hard_trig;   // release on halt or lost priority
    } rule_t;

    localparam logic [STAT_W-1:0] ST_HALT = 3'b011;
    localparam logic [STAT_W-1:0] ST_IDLE = 3'b111;

    function automatic stat_cls_e classify(input logic [STAT_W-1:0] s);
        if (s == ST_HALT)           return CLS_HALT;
        else if (s == ST_IDLE)      return CLS_IDLE;
        else if (s[STAT_W-1])       return CLS_MEM;
        else                        return CLS_IO;
    endfunction

endpackage

// File: rtl/busarb_decode.sv
module busarb_decode
    import busarb_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output stat_cls_e         cls
);
    always_comb cls = classify(stat);
endmodule

// File: rtl/busarb_rules.sv
module busarb_rules
    import busarb_pkg::*;
(
    input  mode_e     mode,
    input  stat_cls_e cls,
    input  logic      sys_sel,
    input  logic      share_req,
    input  logic      prio_lost,
    output rule_t     rule
);
    logic is_io, is_mem, is_halt, is_idle, active;

    always_comb begin
        is_io   = (cls == CLS_IO);
        is_mem  = (cls == CLS_MEM);
        is_halt = (cls == CLS_HALT);
        is_idle = (cls == CLS_IDLE);
        active  = is_io | is_mem;

        rule.hard_trig = is_halt | prio_lost;
        unique case (mode)
            MD_SINGLE: begin
                rule.want       = active;
                rule.share_trig = is_idle & share_req;
            end
            MD_LOCAL: begin
                rule.want       = active & sys_sel;
                rule.share_trig = (is_idle | ~sys_sel) & share_req;
            end
            MD_IOSPLIT: begin
                rule.want       = is_mem;
                rule.share_trig = (is_io | is_idle) & share_req;
            end
            MD_COMBINED: begin
                rule.want       = is_mem & sys_sel;
                rule.share_trig = (is_io | ~sys_sel) & share_req;
            end
            default: begin
                rule.want       = 1'b0;
                rule.share_trig = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/busarb_track.sv
module busarb_track
    import busarb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rule_t rule,
    input  logic  prio_lost,
    input  logic  hold_all,
    input  logic  hold_share,
    output logic  bus_req,
    output logic  bus_owned,
    output logic  pend
);
    logic owned_q, pend_q, owned_d, pend_d;
    logic release_c, gain_c;

    always_comb begin
        release_c = rule.hard_trig | (rule.share_trig & ~hold_share);
        gain_c    = (rule.want | pend_q) & ~prio_lost;
        owned_d   = owned_q ? ~(release_c & ~hold_all) : gain_c;
        pend_d    = ~owned_d & (pend_q | rule.want);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            owned_q <= owned_d;
            pend_q  <= pend_d;
        end
    end

    assign bus_req   = owned_q | pend_q | rule.want;
    assign bus_owned = owned_q;
    assign pend      = pend_q;
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
    import busarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    input  logic              cfg_io_split_n,
    input  logic              cfg_local,
    input  logic              sys_sel,
    input  logic              share_req,
    input  logic              prio_lost,
    input  logic              hold_all,
    input  logic              hold_share,
    output logic              bus_req,
    output logic              bus_owned
);
    stat_cls_e cls;
    rule_t     rule;
    mode_e     mode;
    logic      pend_w;

    assign mode = mode_e'({cfg_io_split_n, cfg_local});

    busarb_decode u_dec (.stat(stat), .cls(cls));

    busarb_rules u_rules (
        .mode(mode), .cls(cls), .sys_sel(sys_sel),
        .share_req(share_req), .prio_lost(prio_lost), .rule(rule)
    );

    busarb_track u_track (
        .clk(clk), .rst(rst), .rule(rule), .prio_lost(prio_lost),
        .hold_all(hold_all), .hold_share(hold_share),
        .bus_req(bus_req), .bus_owned(bus_owned), .pend(pend_w)
    );
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk
    import busarb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [STAT_W-1:0] stat,
    input logic              prio_lost,
    input logic              hold_all,
    input logic              bus_req,
    input logic              bus_owned,
    input logic              pend
);
    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_owned && !pend && (stat == ST_HALT || stat == ST_IDLE)) |-> !bus_req);

    p_prio_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && prio_lost && !hold_all) |=> !bus_owned);

    p_no_gain_prio_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_owned && prio_lost) |=> !bus_owned);

    p_lock_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && hold_all) |=> bus_owned);

    p_gain_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_owned) |-> ($past(bus_req) && !$past(prio_lost)));

    p_halt_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && stat == ST_HALT && !hold_all) |=> !bus_owned);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_owned) |=> (bus_req || bus_owned));
endmodule

bind mm_bus_arbiter busarb_chk u_chk (
    .clk(clk), .rst(rst), .stat(stat), .prio_lost(prio_lost),
    .hold_all(hold_all), .bus_req(bus_req), .bus_owned(bus_owned),
    .pend(pend_w)
);

// File: tb/tb_mm_bus_arbiter.sv
module tb_mm_bus_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat = 3'b111;
    logic       cfg_io_split_n = 1'b1, cfg_local = 1'b0;
    logic       sys_sel = 1'b0, share_req = 1'b0, prio_lost = 1'b0;
    logic       hold_all = 1'b0, hold_share = 1'b0;
    logic       bus_req, bus_owned;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    own;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference state
    bit m_own = 1'b0, m_pend = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mm_bus_arbiter dut (
        .clk(clk), .rst(rst), .stat(stat),
        .cfg_io_split_n(cfg_io_split_n), .cfg_local(cfg_local),
        .sys_sel(sys_sel), .share_req(share_req), .prio_lost(prio_lost),
        .hold_all(hold_all), .hold_share(hold_share),
        .bus_req(bus_req), .bus_owned(bus_owned)
    );

    task automatic check(input bit got, input bit exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b (stat=%b sel=%0b sh=%0b pl=%0b ha=%0b hs=%0b)",
                     what, got, exp, stat, sys_sel, share_req, prio_lost, hold_all, hold_share);
        end
    endtask

    // Requirement-level model: R1 classes, R3..R6 mode rules
    function automatic bit ref_want(input bit [2:0] s, input bit sel);
        bit halt = (s == 3'b011);
        bit idle = (s == 3'b111);
        bit mem  = s[2] && !idle;
        bit act  = !halt && !idle;
        if (cfg_io_split_n && !cfg_local)  return act;          // R3
        if (cfg_io_split_n &&  cfg_local)  return act && sel;   // R4
        if (!cfg_local)                    return mem;          // R5
        return mem && sel;                                      // R6
    endfunction

    function automatic bit ref_share(input bit [2:0] s, input bit sel);
        bit idle = (s == 3'b111);
        bit io   = !s[2];
        if (cfg_io_split_n && !cfg_local)  return idle;
        if (cfg_io_split_n &&  cfg_local)  return idle || !sel;
        if (!cfg_local)                    return io || idle;
        return io || !sel;
    endfunction

    task automatic step(input bit [2:0] s, input bit sel, input bit cr, input bit pl,
                        input bit ha, input bit hs, input string tag);
        bit w, rel, nxt;
        @(negedge clk);
        stat = s; sys_sel = sel; share_req = cr; prio_lost = pl;
        hold_all = ha; hold_share = hs;
        #1;
        w = ref_want(s, sel);
        check(bus_req, m_own || m_pend || w, {tag, " bus_req"});
        rel = (s == 3'b011) || pl || (cr && ref_share(s, sel) && !hs);   // R7, R9
        if (m_own) nxt = !(rel && !ha);                                   // R8
        else       nxt = (w || m_pend) && !pl;                            // R10
        m_pend = !nxt && (m_pend || w);                                   // R11
        m_own  = nxt;
        q.push_back('{own: nxt, tag: tag});
    endtask

    // monitor: bus_owned is due one rising edge after the drive
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(bus_owned, e.own, {e.tag, " R10 bus_owned"});
            end
        end
    end

    task automatic do_reset(input bit io_n, input bit loc);
        @(negedge clk);
        rst = 1'b1;
        cfg_io_split_n = io_n; cfg_local = loc;
        stat = 3'b111; share_req = 1'b0; prio_lost = 1'b0;
        hold_all = 1'b0; hold_share = 1'b0; sys_sel = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(bus_owned, 1'b0, "R12 reset owned");
        check(bus_req, 1'b0, "R12 reset req");
        rst = 1'b0;
        m_own = 1'b0; m_pend = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string mt;
        for (int md = 0; md < 4; md++) begin
            do_reset(md[1], md[0]);
            mt = (md == 2) ? "R3" : (md == 3) ? "R4" : (md == 0) ? "R5" : "R6";
            for (int s = 0; s < 8; s++)
            for (int sel = 0; sel < 2; sel++)
            for (int cr = 0; cr < 2; cr++)
            for (int pl = 0; pl < 2; pl++)
            for (int lk = 0; lk < 4; lk++) begin
                string t;
                t = lk[1] ? "R8" : lk[0] ? "R9" : pl ? "R7" : mt;
                // drain to an unowned, idle-request state
                repeat (3) step(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 halt");
                // from unowned: decode and request rules
                step(3'(s), sel[0], cr[0], pl[0], lk[1], lk[0],
                     (s == 3 || s == 7) ? "R2" : "R1");
                step(3'b111, 1'b0, 1'b0, pl[0], 1'b0, 1'b0, "R11 hold");
                // acquire with a memory command
                step(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, mt);
                // from owned: release rules
                step(3'(s), sel[0], cr[0], pl[0], lk[1], lk[0], t);
                step(3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 lazy");
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule